// File: doc/BRIEF.md
# Pipelined Complex Fractional Multiplier

This block multiplies two complex operands, X and Y, whose real and imaginary parts are 16-bit signed fractions (one sign bit, fifteen fraction bits). The product carries full precision: each component of the result is a 32-bit signed fraction with one sign bit and thirty-one fraction bits. The doubling that takes out the redundant sign bit of each fractional product is part of the datapath. Any result that cannot be represented is clamped to the nearest end of the output range.

The datapath is a four-stage pipeline and accepts a new operand pair on every clock. Each operation carries two control bits. One bit takes the complex conjugate of X and the other takes the conjugate of Y, and both are applied before the multiply. A valid flag travels with the data. When no new result comes out, the output registers keep the last valid result.

Top module: `cxmul_frac`

## Requirements
- R1: For a valid operation, z_re equals 2·(Xr·Yr − Xi·Yi) in units of 2^-31, clamped to the signed 32-bit range. The inputs are read as signed integers scaled by 2^-15.
- R2: For a valid operation, z_im equals 2·(Xr·Yi + Xi·Yr) in units of 2^-31, clamped to the signed 32-bit range.
- R3: When conj_x is 1, the imaginary part of X is negated before the multiply. When conj_y is 1, the same applies to Y. Both bits may be set together.
- R4: Conjugating an imaginary part of −32768 (0x8000) gives +32767 (0x7FFF) and does not wrap.
- R5: A result above 2^31−1 comes out as 0x7FFFFFFF, and one below −2^31 comes out as 0x80000000. In particular, (−1+0j)·(−1+0j) gives z_re = 0x7FFFFFFF and z_im = 0.
- R6: An operation captured with in_valid=1 at clock edge t appears on z_re and z_im with out_valid=1 right after edge t+3, which is four register stages counting the capture.
- R7: Operations may arrive on consecutive clocks with no gaps, and each one produces its own result on consecutive cycles.
- R8: out_valid is 1 only for cycles that carry the result of a valid operation. While out_valid is 0, z_re and z_im hold the last valid result.
- R9: While rst_n is 0 (asynchronous, active low), out_valid is 0 and z_re and z_im are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair present this cycle |
| x_re | input | 16 | Real part of X, signed fraction |
| x_im | input | 16 | Imaginary part of X, signed fraction |
| y_re | input | 16 | Real part of Y, signed fraction |
| y_im | input | 16 | Imaginary part of Y, signed fraction |
| conj_x | input | 1 | Conjugate X for this operation |
| conj_y | input | 1 | Conjugate Y for this operation |
| out_valid | output | 1 | Result present this cycle |
| z_re | output | 32 | Real part of product, signed fraction |
| z_im | output | 32 | Imaginary part of product, signed fraction |

## Verification
The timing properties assume that rst_n is released between clock edges and that in_valid is driven to a known level from the first cycle after release. The latency and extreme-value properties look back exactly four edges, so they assume the operands at each capture edge are stable, fully driven values. The stimulus changes every input only at falling edges and never leaves in_valid or an operand undriven after reset. It mixes gapless random runs, bubbles, and directed operands at the range ends (−1, +1−2^-15, 0), with every combination of the two conjugate bits.

// File: rtl/cxmul_pkg.sv
package cxmul_pkg;
   // number of register stages from capture to output
   localparam int LAT = 4;
   // how a combiner joins its two partial products
   typedef enum logic [0:0] {OP_ADD = 1'b0, OP_SUB = 1'b1} cx_op_e;
endpackage

// File: rtl/cxmul_conj.sv
// Optional saturating negation of one imaginary part.
module cxmul_conj #(
   parameter int DW = 16
) (
   input  logic signed [DW-1:0] im_i,
   input  logic                 neg_i,
   output logic signed [DW-1:0] im_o
);
   localparam logic signed [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};
   localparam logic signed [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};

   always_comb begin
      if (!neg_i)           im_o = im_i;
      else if (im_i == MINV) im_o = MAXV;
      else                  im_o = -im_i;
   end
endmodule

// File: rtl/cxmul_prod.sv
// Registered signed product of two fractions (raw integer product).
module cxmul_prod #(
   parameter int DW = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   en,
   input  logic signed [DW-1:0]   a_i,
   input  logic signed [DW-1:0]   b_i,
   output logic signed [2*DW-1:0] p_o
);
   localparam int PW = 2 * DW;

   logic signed [PW-1:0] prod_c;
   assign prod_c = PW'(a_i) * PW'(b_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  p_o <= '0;
      else if (en) p_o <= prod_c;
   end
endmodule

// File: rtl/cxmul_comb.sv
// Two-stage combiner: add or subtract partial products, then double and clamp.
module cxmul_comb #(
   parameter int               DW = 16,
   parameter cxmul_pkg::cx_op_e OP = cxmul_pkg::OP_ADD
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   en_sum,
   input  logic                   en_out,
   input  logic signed [2*DW-1:0] pa_i,
   input  logic signed [2*DW-1:0] pb_i,
   output logic signed [2*DW-1:0] z_o
);
   localparam int PW = 2 * DW;
   localparam int SW = PW + 1;
   localparam logic signed [PW-1:0] MAXO = {1'b0, {(PW-1){1'b1}}};
   localparam logic signed [PW-1:0] MINO = {1'b1, {(PW-1){1'b0}}};

   logic signed [SW-1:0] sum_c, sum_q;
   logic signed [SW:0]   dbl_c;
   logic                 fits_c;
   logic signed [PW-1:0] sat_c;

   generate
      if (OP == cxmul_pkg::OP_SUB) begin : g_sub
         assign sum_c = SW'(pa_i) - SW'(pb_i);
      end else begin : g_add
         assign sum_c = SW'(pa_i) + SW'(pb_i);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sum_q <= '0;
      else if (en_sum) sum_q <= sum_c;
   end

   // doubling drops the redundant sign bit of a fractional product
   assign dbl_c  = {sum_q, 1'b0};
   assign fits_c = (dbl_c[SW] == dbl_c[SW-1]) && (dbl_c[SW-1] == dbl_c[PW-1]);

   always_comb begin
      if (fits_c)        sat_c = dbl_c[PW-1:0];
      else if (dbl_c[SW]) sat_c = MINO;
      else               sat_c = MAXO;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      z_o <= '0;
      else if (en_out) z_o <= sat_c;
   end
endmodule

// File: rtl/cxmul_frac.sv
// Four-stage complex fractional multiplier with per-operand conjugation.
module cxmul_frac #(
   parameter int DW = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic signed [DW-1:0]   x_re,
   input  logic signed [DW-1:0]   x_im,
   input  logic signed [DW-1:0]   y_re,
   input  logic signed [DW-1:0]   y_im,
   input  logic                   conj_x,
   input  logic                   conj_y,
   output logic                   out_valid,
   output logic signed [2*DW-1:0] z_re,
   output logic signed [2*DW-1:0] z_im
);
   localparam int PW     = 2 * DW;
   localparam int NOPS   = 2;   // operands X and Y
   localparam int NPROD  = 4;   // partial products
   localparam int NCOMP  = 2;   // result components

   generate
      if (DW < 4 || DW > 32) begin : g_bad_dw
         $error("cxmul_frac: DW must lie in 4..32");
      end
      if (cxmul_pkg::LAT != 4) begin : g_bad_lat
         $error("cxmul_frac: datapath is built for four stages");
      end
   endgenerate

   // ---------------- stage 1: conjugate and capture ----------------
   logic signed [DW-1:0] im_in [NOPS];
   logic                 neg_in[NOPS];
   logic signed [DW-1:0] im_cj [NOPS];
   logic signed [DW-1:0] xi_cj, yi_cj;

   always_comb begin
      im_in[0]  = x_im;  neg_in[0] = conj_x;
      im_in[1]  = y_im;  neg_in[1] = conj_y;
   end

   generate
      for (genvar g = 0; g < NOPS; g++) begin : g_conj
         cxmul_conj #(.DW(DW)) u_conj (
            .im_i (im_in[g]),
            .neg_i(neg_in[g]),
            .im_o (im_cj[g])
         );
      end
   endgenerate

   assign xi_cj = im_cj[0];
   assign yi_cj = im_cj[1];

   logic signed [DW-1:0] xr1, xi1, yr1, yi1;
   logic                 v1, v2, v3, v4;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         xr1 <= '0; xi1 <= '0; yr1 <= '0; yi1 <= '0;
      end else if (in_valid) begin
         xr1 <= x_re; xi1 <= xi_cj; yr1 <= y_re; yi1 <= yi_cj;
      end
   end

   // valid flag rides alongside the data
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v1 <= 1'b0; v2 <= 1'b0; v3 <= 1'b0; v4 <= 1'b0;
      end else begin
         v1 <= in_valid; v2 <= v1; v3 <= v2; v4 <= v3;
      end
   end

   // ---------------- stage 2: partial products ----------------
   // index 0: Xr*Yr, 1: Xi*Yi, 2: Xr*Yi, 3: Xi*Yr
   logic signed [DW-1:0] opa[NPROD];
   logic signed [DW-1:0] opb[NPROD];
   logic signed [PW-1:0] pp [NPROD];

   always_comb begin
      opa[0] = xr1; opb[0] = yr1;
      opa[1] = xi1; opb[1] = yi1;
      opa[2] = xr1; opb[2] = yi1;
      opa[3] = xi1; opb[3] = yr1;
   end

   generate
      for (genvar g = 0; g < NPROD; g++) begin : g_prod
         cxmul_prod #(.DW(DW)) u_prod (
            .clk  (clk),
            .rst_n(rst_n),
            .en   (v1),
            .a_i  (opa[g]),
            .b_i  (opb[g]),
            .p_o  (pp[g])
         );
      end
   endgenerate

   // ---------------- stages 3 and 4: combine, double, clamp ----------------
   logic signed [PW-1:0] zc[NCOMP];

   generate
      for (genvar g = 0; g < NCOMP; g++) begin : g_comp
         cxmul_comb #(
            .DW(DW),
            .OP((g == 0) ? cxmul_pkg::OP_SUB : cxmul_pkg::OP_ADD)
         ) u_comb (
            .clk   (clk),
            .rst_n (rst_n),
            .en_sum(v2),
            .en_out(v3),
            .pa_i  (pp[2*g]),
            .pb_i  (pp[2*g+1]),
            .z_o   (zc[g])
         );
      end
   endgenerate

   assign z_re      = zc[0];
   assign z_im      = zc[1];
   assign out_valid = v4;
endmodule

// File: rtl/cxmul_frac_chk.sv
module cxmul_frac_chk #(
   parameter int DW = 16
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   in_valid,
   input logic signed [DW-1:0]   x_re,
   input logic signed [DW-1:0]   x_im,
   input logic signed [DW-1:0]   y_re,
   input logic signed [DW-1:0]   y_im,
   input logic                   conj_x,
   input logic                   conj_y,
   input logic signed [DW-1:0]   xi_cj,
   input logic signed [DW-1:0]   yi_cj,
   input logic                   out_valid,
   input logic signed [2*DW-1:0] z_re,
   input logic signed [2*DW-1:0] z_im
);
   localparam int PW = 2 * DW;
   localparam logic signed [DW-1:0] MINI = {1'b1, {(DW-1){1'b0}}};
   localparam logic signed [DW-1:0] MAXI = {1'b0, {(DW-1){1'b1}}};
   localparam logic signed [PW-1:0] MAXO = {1'b0, {(PW-1){1'b1}}};

   // edges seen since reset release, saturating at the latency
   logic [2:0] age;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      age <= '0;
      else if (age < 3'(cxmul_pkg::LAT)) age <= age + 3'd1;
   end

   // R6: result valid exactly four edges after capture
   a_r6_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 3'(cxmul_pkg::LAT)) |-> (out_valid == $past(in_valid, 4)));

   // R8: outputs hold while no result is presented
   a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (age != 3'd0 && !out_valid) |-> ($stable(z_re) && $stable(z_im)));

   // R4: conjugating the most negative imaginary part clamps
   a_r4_conj_min: assert property (@(posedge clk) disable iff (!rst_n)
      (conj_x && x_im == MINI) |-> (xi_cj == MAXI));

   // R3: conjugation of Y negates its imaginary part
   a_r3_conj_neg: assert property (@(posedge clk) disable iff (!rst_n)
      (conj_y && y_im != MINI) |-> (yi_cj == -y_im));

   // R5: (-1)*(-1) clamps to the largest positive value
   a_r5_neg_one_sq: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 3'(cxmul_pkg::LAT) && out_valid && $past(x_re, 4) == MINI &&
       $past(y_re, 4) == MINI && $past(x_im, 4) == '0 && $past(y_im, 4) == '0)
      |-> (z_re == MAXO && z_im == '0));

   // R9: reset clears the result
   always @(posedge clk) begin
      if (!rst_n) begin
         a_r9_reset_clear: assert (!out_valid && z_re == '0 && z_im == '0);
      end
   end
endmodule

bind cxmul_frac cxmul_frac_chk #(.DW(DW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .x_re     (x_re),
   .x_im     (x_im),
   .y_re     (y_re),
   .y_im     (y_im),
   .conj_x   (conj_x),
   .conj_y   (conj_y),
   .xi_cj    (xi_cj),
   .yi_cj    (yi_cj),
   .out_valid(out_valid),
   .z_re     (z_re),
   .z_im     (z_im)
);

// File: tb/cxmul_frac_test.sv
module cxmul_frac_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic signed [15:0] x_re = '0, x_im = '0, y_re = '0, y_im = '0;
   logic conj_x = 1'b0, conj_y = 1'b0;
   logic out_valid;
   logic signed [31:0] z_re, z_im;

   int total = 0;
   int bad = 0;

   always #4 clk = ~clk;

   cxmul_frac uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .x_re(x_re), .x_im(x_im), .y_re(y_re), .y_im(y_im),
      .conj_x(conj_x), .conj_y(conj_y),
      .out_valid(out_valid), .z_re(z_re), .z_im(z_im)
   );

   // reference model state: queue of in-flight operations, four deep
   logic   ev[4];
   longint er[4];
   longint ei[4];
   string  et[4];
   longint last_re = 0, last_im = 0;

   function automatic longint neg_im(longint v, logic c);
      if (!c) return v;
      if (v == -32768) return 32767;
      return -v;
   endfunction

   function automatic longint clamp32(longint v);
      if (v > 64'sd2147483647) return 64'sd2147483647;
      if (v < -64'sd2147483648) return -64'sd2147483648;
      return v;
   endfunction

   task automatic check(string tag, longint act, longint exp_v, string what);
      total++;
      if (act != exp_v) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp_v);
      end
   endtask

   task automatic step(input logic v, input logic signed [15:0] a, b, c, d,
                       input logic cx, cy, input string tag);
      longint xr, xi, yr, yi;
      in_valid = v; x_re = a; x_im = b; y_re = c; y_im = d; conj_x = cx; conj_y = cy;
      @(posedge clk);
      @(negedge clk);
      xr = longint'(a); yr = longint'(c);
      xi = neg_im(longint'(b), cx);
      yi = neg_im(longint'(d), cy);
      for (int k = 3; k > 0; k--) begin
         ev[k] = ev[k-1]; er[k] = er[k-1]; ei[k] = ei[k-1]; et[k] = et[k-1];
      end
      ev[0] = v;
      er[0] = clamp32(2 * (xr * yr - xi * yi));
      ei[0] = clamp32(2 * (xr * yi + xi * yr));
      et[0] = tag;
      // R6 and R8: valid four stages later, otherwise hold
      check(ev[3] ? et[3] : "R8", longint'(out_valid), longint'(ev[3]), "out_valid");
      if (ev[3]) begin
         last_re = er[3];
         last_im = ei[3];
      end
      check(ev[3] ? {et[3], "/R1"} : "R8", longint'(z_re), last_re, "z_re");
      check(ev[3] ? {et[3], "/R2"} : "R8", longint'(z_im), last_im, "z_im");
   endtask

   task automatic idle();
      step(1'b0, 16'sd0, 16'sd0, 16'sd0, 16'sd0, 1'b0, 1'b0, "R8");
   endtask

   initial begin
      #(8 * 200000);
      bad++;
      total++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int k = 0; k < 4; k++) begin
         ev[k] = 1'b0; er[k] = 0; ei[k] = 0; et[k] = "R8";
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R9: reset state
      check("R9", longint'(out_valid), 0, "out_valid");
      check("R9", longint'(z_re), 0, "z_re");
      check("R9", longint'(z_im), 0, "z_im");
      rst_n = 1'b1;

      // R1/R2: plain products, 0.5 * 0.5 and mixed signs
      step(1'b1, 16'sh4000, 16'sh0000, 16'sh4000, 16'sh0000, 1'b0, 1'b0, "R1");
      step(1'b1, 16'sh2000, -16'sh1000, 16'sh3000, 16'sh0800, 1'b0, 1'b0, "R2");
      // R3: conjugation of X, of Y, and of both
      step(1'b1, 16'sh1234, 16'sh2345, -16'sh3456, 16'sh0456, 1'b1, 1'b0, "R3");
      step(1'b1, 16'sh1234, 16'sh2345, -16'sh3456, 16'sh0456, 1'b0, 1'b1, "R3");
      step(1'b1, 16'sh1234, 16'sh2345, -16'sh3456, 16'sh0456, 1'b1, 1'b1, "R3");
      // R4: conjugating -1 imaginary parts
      step(1'b1, 16'sh4000, -16'sh8000, 16'sh4000, -16'sh8000, 1'b1, 1'b1, "R4");
      step(1'b1, 16'sh0000, -16'sh8000, 16'sh0000, 16'sh7fff, 1'b1, 1'b0, "R4");
      // R5: (-1)*(-1), positive and negative overflow
      step(1'b1, -16'sh8000, 16'sh0000, -16'sh8000, 16'sh0000, 1'b0, 1'b0, "R5");
      step(1'b1, -16'sh8000, -16'sh8000, -16'sh8000, 16'sh7fff, 1'b0, 1'b0, "R5");
      step(1'b1, -16'sh8000, 16'sh7fff, 16'sh7fff, 16'sh7fff, 1'b0, 1'b0, "R5");
      step(1'b1, -16'sh8000, -16'sh8000, -16'sh8000, -16'sh8000, 1'b0, 1'b1, "R5");
      // R8: bubbles keep the last result
      repeat (6) idle();
      // R6: single isolated operation after idle
      step(1'b1, 16'sh7fff, 16'sh7fff, 16'sh7fff, -16'sh7fff, 1'b0, 1'b0, "R6");
      repeat (5) idle();
      // R7: long gapless run with corner-biased random operands
      for (int n = 0; n < 300; n++) begin
         logic [31:0] r;
         logic signed [15:0] ops[4];
         for (int q = 0; q < 4; q++) begin
            r = $urandom;
            case (r[19:17])
               3'd0:    ops[q] = -16'sh8000;
               3'd1:    ops[q] = 16'sh7fff;
               3'd2:    ops[q] = 16'sh0000;
               default: ops[q] = r[15:0];
            endcase
         end
         r = $urandom;
         step((n % 37 == 36) ? 1'b0 : 1'b1, ops[0], ops[1], ops[2], ops[3],
              r[0], r[1], "R7");
      end
      repeat (6) idle();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule